// File: doc/BRIEF.md
# I/O Address Decoder with Bitwise Control Latch

This block sits on an 8-bit peripheral I/O bus whose data path is separated from the processor bus by a bidirectional transceiver. The lowest address bit fixes the transfer direction: odd addresses carry writes and even addresses carry reads. The block drives the transceiver direction from that bit. It turns address bits 7..4 into one-clock select strobes for the attached peripherals, and it answers reads of two status bytes built from switch rows, encoder phases, footswitch contacts and jack-sense inputs.

It also holds an 8-bit control register. Each write changes exactly one bit of it, and the address alone determines the change: bits 4..2 pick the bit and bit 1 chooses set or clear. The block has no write-data input. After reset every control bit is 0. Because the processor resets and the output mute are active low, they stay asserted until software releases them one at a time. Status inputs pass through a two-stage synchronizer before they reach the read path.

Top module: `io_decoder_top`

## Requirements
- R1: `xcvr_dir` always equals `io_addr[0]` in the same cycle (1 = write direction, 0 = read direction).
- R2: A write cycle (`io_wr`=1, `io_cs`=1) at an odd address drives `wr_stb[io_addr[7:4]]` high for exactly the clock after the sampling edge, and no other bit. Only the write slots 0, 2, 4, 6, 8, 9, 10, 12 and 14 pulse; writes to the remaining slots pulse nothing.
- R3: A read cycle (`io_rd`=1, `io_cs`=1) at an even address drives `rd_stb[io_addr[7:4]]` high for one clock after the sampling edge. Only the read slots 0, 1 and 12 pulse.
- R4: A read at an odd address, or a write at an even address, produces no strobe and leaves `ctrl_q` unchanged. The read at an odd address returns `io_dout` = 0xFF.
- R5: A read of slot 0 at an even address returns `{3'b000, pot_fb, sw_row[3:0]}` on `io_dout` from the clock after the sampling edge.
- R6: A read of slot 1 at an even address returns `{2'b00, jack_r_n, jack_l_n, fsw_ring, fsw_tip, enc_b, enc_a}`. Any other read returns 0xFF, and so does any cycle without a valid read.
- R7: A valid write whose address has bits 7..5 equal to 000 (addresses 0x01..0x1F, odd) sets `ctrl_q[io_addr[4:2]]` when `io_addr[1]`=1 and clears it when `io_addr[1]`=0, and leaves all other bits unchanged. For example, 0x03 sets bit 0, 0x01 clears it and 0x17 sets bit 5.
- R8: While `rst` is high at a clock edge, `ctrl_q` becomes 0x00, both strobe vectors become 0 and `io_dout` becomes 0xFF.
- R9: A status input that changes before edge n is reflected in read data registered at edge n+2, and not in read data registered at edge n or n+1.
- R10: With `io_cs`=0, no strobe is produced, `ctrl_q` does not change and `io_dout` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | I/O address; bit 0 gives the direction |
| io_rd | input | 1 | Read cycle request |
| io_wr | input | 1 | Write cycle request |
| io_cs | input | 1 | I/O space chip select |
| xcvr_dir | output | 1 | Transceiver direction, 1 = write |
| io_dout | output | 8 | Registered read data |
| wr_stb | output | 16 | One-clock write selects, indexed by address bits 7..4 |
| rd_stb | output | 16 | One-clock read selects, indexed by address bits 7..4 |
| sw_row | input | 4 | Switch matrix row returns |
| pot_fb | input | 1 | Serial feedback from the potentiometer chain |
| enc_a | input | 1 | Encoder phase A |
| enc_b | input | 1 | Encoder phase B |
| fsw_tip | input | 1 | Footswitch tip contact |
| fsw_ring | input | 1 | Footswitch ring contact |
| jack_l_n | input | 1 | Left return jack sense, 0 = plug inserted |
| jack_r_n | input | 1 | Right return jack sense, 0 = plug inserted |
| ctrl_q | output | 8 | Control bits: 0 DSP reset_n, 1 mute_n, 2 effects reset_n, 3 aux mono sum, 4 speaker-sim freq A, 5 speaker-sim freq B, 6..7 spare |

## Verification
The hardest case to reach is the status-read timing. Read data must lag a status input change by exactly the synchronizer depth, so the change and the read request have to land on the same edge. A directed sequence changes every status input and issues slot-0 and slot-1 reads on that edge and on the two edges that follow, and it expects the old, old and new value in turn. Random traffic also mixes mismatched directions, deselected cycles and the upper control window 0x11..0x1F. Those addresses share address bit 4 with status slot 1, so the model has to tell a latch write apart from a slot strobe.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int SLOT_W    = 4;
  localparam int N_SLOTS   = 1 << SLOT_W;
  localparam int CTRL_BITS = 8;
  localparam int STAT_W    = 11;

  localparam logic [N_SLOTS-1:0] WR_SLOT_MASK = 16'h5755;
  localparam logic [N_SLOTS-1:0] RD_SLOT_MASK = 16'h1003;

  localparam logic [SLOT_W-1:0] SLOT_STAT1 = 4'h0;
  localparam logic [SLOT_W-1:0] SLOT_STAT2 = 4'h1;

  typedef struct packed {
    logic       jack_r_n;
    logic       jack_l_n;
    logic       fsw_ring;
    logic       fsw_tip;
    logic       enc_b;
    logic       enc_a;
    logic       pot_fb;
    logic [3:0] sw_row;
  } stat_vec_t;

  function automatic logic [DATA_W-1:0] fmt_stat1(input stat_vec_t s);
    return {3'b000, s.pot_fb, s.sw_row};
  endfunction

  function automatic logic [DATA_W-1:0] fmt_stat2(input stat_vec_t s);
    return {2'b00, s.jack_r_n, s.jack_l_n, s.fsw_ring, s.fsw_tip, s.enc_b, s.enc_a};
  endfunction
endpackage

// File: rtl/io_status_sync.sv
module io_status_sync #(
  parameter int WIDTH  = 11,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= '0;
        else if (g == 0) stage[g] <= d;
        else stage[g] <= stage[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/io_addr_decode.sv
module io_addr_decode #(
  parameter int                      SLOT_W  = 4,
  parameter logic [(1<<SLOT_W)-1:0]  WR_MASK = '1,
  parameter logic [(1<<SLOT_W)-1:0]  RD_MASK = '1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [SLOT_W-1:0]        slot,
  input  logic                     a0,
  input  logic                     rd,
  input  logic                     wr,
  input  logic                     cs,
  output logic                     wr_ok,
  output logic                     rd_ok,
  output logic [(1<<SLOT_W)-1:0]   wr_stb,
  output logic [(1<<SLOT_W)-1:0]   rd_stb
);
  localparam int N = 1 << SLOT_W;

  // direction must agree with address bit 0
  assign wr_ok = wr & cs & a0;
  assign rd_ok = rd & cs & ~a0;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_slot
      if (WR_MASK[g]) begin : g_wr
        always_ff @(posedge clk) begin
          if (rst) wr_stb[g] <= 1'b0;
          else     wr_stb[g] <= wr_ok && (slot == SLOT_W'(g));
        end
      end else begin : g_wr_none
        assign wr_stb[g] = 1'b0;
      end
      if (RD_MASK[g]) begin : g_rd
        always_ff @(posedge clk) begin
          if (rst) rd_stb[g] <= 1'b0;
          else     rd_stb[g] <= rd_ok && (slot == SLOT_W'(g));
        end
      end else begin : g_rd_none
        assign rd_stb[g] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/io_ctrl_latch.sv
module io_ctrl_latch #(
  parameter int ADDR_W    = 8,
  parameter int CTRL_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_ok,
  input  logic [ADDR_W-1:1]    addr_hi,
  output logic [CTRL_BITS-1:0] q
);
  localparam int SEL_W = $clog2(CTRL_BITS);
  localparam int WIN_LO = 2 + SEL_W;

  logic             in_window;
  logic [SEL_W-1:0] bit_sel;
  logic             set_val;

  assign in_window = (addr_hi[ADDR_W-1:WIN_LO] == '0);
  assign bit_sel   = addr_hi[WIN_LO-1:2];
  assign set_val   = addr_hi[1];

  genvar g;
  generate
    for (g = 0; g < CTRL_BITS; g++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) q[g] <= 1'b0;
        else if (wr_ok && in_window && bit_sel == SEL_W'(g)) q[g] <= set_val;
      end
    end
  endgenerate
endmodule

// File: rtl/io_read_mux.sv
module io_read_mux
  import io_dec_pkg::*;
#(
  parameter int SLOT_W_P = SLOT_W,
  parameter int DATA_W_P = DATA_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_ok,
  input  logic [SLOT_W_P-1:0] slot,
  input  stat_vec_t           stat,
  output logic [DATA_W_P-1:0] dout
);
  logic [DATA_W_P-1:0] nxt;

  always_comb begin
    nxt = '1;
    if (rd_ok) begin
      if (slot == SLOT_W_P'(SLOT_STAT1))      nxt = DATA_W_P'(fmt_stat1(stat));
      else if (slot == SLOT_W_P'(SLOT_STAT2)) nxt = DATA_W_P'(fmt_stat2(stat));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '1;
    else     dout <= nxt;
  end
endmodule

// File: rtl/io_decoder_top.sv
module io_decoder_top
  import io_dec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic                 io_rd,
  input  logic                 io_wr,
  input  logic                 io_cs,
  output logic                 xcvr_dir,
  output logic [DATA_W-1:0]    io_dout,
  output logic [N_SLOTS-1:0]   wr_stb,
  output logic [N_SLOTS-1:0]   rd_stb,
  input  logic [3:0]           sw_row,
  input  logic                 pot_fb,
  input  logic                 enc_a,
  input  logic                 enc_b,
  input  logic                 fsw_tip,
  input  logic                 fsw_ring,
  input  logic                 jack_l_n,
  input  logic                 jack_r_n,
  output logic [CTRL_BITS-1:0] ctrl_q
);
  logic              wr_ok, rd_ok;
  logic [SLOT_W-1:0] slot;
  stat_vec_t         stat_raw, stat_sync;

  assign xcvr_dir = io_addr[0];
  assign slot     = io_addr[ADDR_W-1:ADDR_W-SLOT_W];

  assign stat_raw = '{jack_r_n: jack_r_n, jack_l_n: jack_l_n, fsw_ring: fsw_ring,
                      fsw_tip: fsw_tip, enc_b: enc_b, enc_a: enc_a,
                      pot_fb: pot_fb, sw_row: sw_row};

  io_addr_decode #(
    .SLOT_W (SLOT_W),
    .WR_MASK(WR_SLOT_MASK),
    .RD_MASK(RD_SLOT_MASK)
  ) u_dec (
    .clk(clk), .rst(rst), .slot(slot), .a0(io_addr[0]),
    .rd(io_rd), .wr(io_wr), .cs(io_cs),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .wr_stb(wr_stb), .rd_stb(rd_stb)
  );

  io_status_sync #(.WIDTH(STAT_W), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(stat_raw), .q(stat_sync)
  );

  io_ctrl_latch #(.ADDR_W(ADDR_W), .CTRL_BITS(CTRL_BITS)) u_ctrl (
    .clk(clk), .rst(rst), .wr_ok(wr_ok),
    .addr_hi(io_addr[ADDR_W-1:1]), .q(ctrl_q)
  );

  io_read_mux u_rmux (
    .clk(clk), .rst(rst), .rd_ok(rd_ok), .slot(slot),
    .stat(stat_sync), .dout(io_dout)
  );
endmodule

// File: rtl/io_decoder_chk.sv
module io_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  io_addr,
  input logic        io_rd,
  input logic        io_wr,
  input logic        io_cs,
  input logic [7:0]  io_dout,
  input logic [15:0] wr_stb,
  input logic [15:0] rd_stb,
  input logic [7:0]  ctrl_q
);
  AST_WR_STB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_stb)); // R2

  AST_WR_STB_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (wr_stb != '0) |-> $past(io_wr && io_cs && io_addr[0])); // R2

  AST_RD_STB_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (rd_stb != '0) |-> $past(io_rd && io_cs && !io_addr[0])); // R3

  AST_NO_WR_MISMATCH: assert property (@(posedge clk) disable iff (rst)
    (io_wr && !io_addr[0]) |=> (wr_stb == '0)); // R4

  AST_ODD_READ_FF: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_cs && io_addr[0]) |=> (io_dout == 8'hFF)); // R4

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && io_cs && io_addr[0] && io_addr[7:5] == 3'b000) |=> $stable(ctrl_q)); // R7

  AST_CTRL_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    $countones(ctrl_q ^ $past(ctrl_q)) <= 1); // R7

  AST_NO_CS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !io_cs |=> (wr_stb == '0 && rd_stb == '0 && io_dout == 8'hFF)); // R10
endmodule

bind io_decoder_top io_decoder_chk u_chk (.*);

// File: tb/io_decoder_top_tb.sv
`timescale 1ns/1ps
module io_decoder_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  io_addr = 8'h00;
  logic        io_rd = 1'b0, io_wr = 1'b0, io_cs = 1'b0;
  logic        xcvr_dir;
  logic [7:0]  io_dout;
  logic [15:0] wr_stb, rd_stb;
  logic [3:0]  sw_row = 4'h0;
  logic        pot_fb = 0, enc_a = 0, enc_b = 0, fsw_tip = 0, fsw_ring = 0;
  logic        jack_l_n = 1, jack_r_n = 1;
  logic [7:0]  ctrl_q;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_ctrl = 8'h00;
  logic [10:0] stat_now;   // values held stable long enough to be seen

  always #2.5 clk = ~clk;

  io_decoder_top u_dut (.*);

  localparam logic [15:0] WRM = 16'h5755;
  localparam logic [15:0] RDM = 16'h1003;

  function automatic logic [10:0] pack_stat();
    return {jack_r_n, jack_l_n, fsw_ring, fsw_tip, enc_b, enc_a, pot_fb, sw_row};
  endfunction

  function automatic logic [15:0] f_wr(logic [7:0] a, logic w, logic c);
    if (w && c && a[0] && WRM[a[7:4]]) return 16'h1 << a[7:4];
    return 16'h0;
  endfunction

  function automatic logic [15:0] f_rd(logic [7:0] a, logic r, logic c);
    if (r && c && !a[0] && RDM[a[7:4]]) return 16'h1 << a[7:4];
    return 16'h0;
  endfunction

  function automatic logic [7:0] f_dout(logic [7:0] a, logic r, logic c, logic [10:0] s);
    if (r && c && !a[0]) begin
      if (a[7:4] == 4'h0) return {3'b000, s[4:0]};
      if (a[7:4] == 4'h1) return {2'b00, s[10:5]};
    end
    return 8'hFF;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_stat(logic [10:0] v);
    {jack_r_n, jack_l_n, fsw_ring, fsw_tip, enc_b, enc_a, pot_fb, sw_row} = v;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  // called at a negedge; checks outputs at the following negedge
  task automatic access(logic [7:0] a, logic r, logic w, logic c, logic [10:0] s_exp);
    logic [15:0] ew, er;
    logic [7:0]  ed;
    io_addr = a; io_rd = r; io_wr = w; io_cs = c;
    #1;
    chk("R1 xcvr_dir", {15'h0, xcvr_dir}, {15'h0, a[0]});
    ew = f_wr(a, w, c);
    er = f_rd(a, r, c);
    ed = f_dout(a, r, c, s_exp);
    if (w && c && a[0] && a[7:5] == 3'b000) exp_ctrl[a[4:2]] = a[1];
    @(posedge clk); @(negedge clk);
    chk(c ? "R2 wr_stb" : "R10 wr_stb", wr_stb, ew);
    chk(c ? "R3 rd_stb" : "R10 rd_stb", rd_stb, er);
    chk((a[0] && r) ? "R4 dout" : (a[7:4] == 4'h1 ? "R6 dout" : "R5 dout"),
        {8'h0, io_dout}, {8'h0, ed});
    chk("R7 ctrl_q", {8'h0, ctrl_q}, {8'h0, exp_ctrl});
    io_rd = 0; io_wr = 0; io_cs = 0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1D0C;
    void'($urandom(seed));
    stat_now = pack_stat();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    chk("R8 ctrl", {8'h0, ctrl_q}, 16'h0);
    chk("R8 wr_stb", wr_stb, 16'h0);
    chk("R8 rd_stb", rd_stb, 16'h0);
    chk("R8 dout", {8'h0, io_dout}, 16'h00FF);
    rst = 0;
    idle(2);

    // R7 directed: set bits 0,1,2 and 5, clear bit 1
    access(8'h03, 0, 1, 1, stat_now);
    access(8'h07, 0, 1, 1, stat_now);
    access(8'h0B, 0, 1, 1, stat_now);
    access(8'h17, 0, 1, 1, stat_now);
    access(8'h05, 0, 1, 1, stat_now);
    chk("R7 pattern", {8'h0, ctrl_q}, 16'h0025);
    // R4 write at even address to latch window: nothing changes
    access(8'h02, 0, 1, 1, stat_now);
    // R10 deselected write
    access(8'h01, 0, 1, 0, stat_now);
    // R4 odd read returns FF
    access(8'h01, 1, 0, 1, stat_now);
    // R3 lcd read, R2 lcd/speaker write
    access(8'hC0, 1, 0, 1, stat_now);
    access(8'hC1, 0, 1, 1, stat_now);
    access(8'h91, 0, 1, 1, stat_now);
    access(8'h31, 0, 1, 1, stat_now);

    // R9 directed synchronizer latency
    set_stat(11'h000); idle(3); stat_now = pack_stat();
    set_stat(11'h7FF);
    access(8'h00, 1, 0, 1, 11'h000);  // edge n: old value
    access(8'h10, 1, 0, 1, 11'h000);  // edge n+2 lands here? no: each access spans one edge
    // each access uses one sampling edge: n, n+1 done above; n+2 below gives new
    access(8'h00, 1, 0, 1, 11'h7FF);
    chk("R9 settled", {8'h0, io_dout}, 16'h001F);
    stat_now = pack_stat();

    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      int op;
      if (($urandom % 16) == 0) begin
        set_stat(11'($urandom));
        idle(2);
        stat_now = pack_stat();
      end
      a  = 8'($urandom);
      op = $urandom % 3;
      access(a, op == 1, op == 2, ($urandom % 8) != 0, stat_now);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule